// File: doc/BRIEF.md
# Twice-Written Control Register Pair

This block holds two 8-bit control registers that sit behind a simple processor bus. A write does not take effect on its own. A value commits only when the same register receives the same byte twice in a row, and the spacing between the two strobes must fall inside a bounded window. The window is set in clock cycles by `MIN_CYC` and `MAX_CYC`. At a 100 MHz clock, 35 cycles is 350 ns and 2000 cycles is 20 µs. A write that breaks the pattern throws away the half-finished sequence and becomes the first write of a new one.

Committed values drive downstream logic directly, and each register has a one-cycle commit pulse so that logic can sample the new value. The first register has two fixed bits at its bottom and a self-clearing soft-reset bit at its top. Committing that bit returns both registers to their power-up values and pulses a clear-coefficients output. Readback is combinational and always shows committed state, never a pending first write.

Top module: `dwreg_bank`

## Requirements
- R1: After reset, register A (address 0x20) holds 0x02, register B (address 0x21) holds 0x00, and every pulse output is low.
- R2: A register commits when a write to it is followed by a write to the same address with the same data. The gap, counted as clock edges between the two write cycles, must lie in [MIN_CYC, MAX_CYC] inclusive. The new value and the commit pulse appear on the clock edge that samples the second write.
- R3: A matching second write whose gap is below MIN_CYC does not commit, and it becomes a new first write.
- R4: A matching second write whose gap is above MAX_CYC does not commit, and it becomes a new first write.
- R5: A second write with different data does not commit, and it becomes a new first write.
- R6: A write to any other address discards a pending first write. This includes the other register and unmapped addresses. A write to an unmapped address never starts a sequence.
- R7: On a commit to register A, bits [1:0] are stored as 2'b10 whatever the written data.
- R8: Committing register A with bit 7 set loads 0x02 into A and 0x00 into B, so bit 7 reads back 0. In that same cycle it raises clr_coef_o, commit_a_o and commit_b_o for one cycle.
- R9: bus_rdata shows committed register A at address 0x20 and committed register B at 0x21, with no added latency. All other addresses read 0x00. A pending write is never visible on it.
- R10: Each commit pulse is high for exactly one cycle per commit and is low in every cycle without a commit.
- R11: After a commit, a further identical write does not commit by itself. It starts a new two-write sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address for writes and reads |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Committed value at bus_addr |
| ctl_a_o | output | 8 | Committed register A |
| ctl_b_o | output | 8 | Committed register B |
| commit_a_o | output | 1 | One-cycle pulse when register A is loaded |
| commit_b_o | output | 1 | One-cycle pulse when register B is loaded |
| clr_coef_o | output | 1 | One-cycle pulse on a soft reset |

## Verification
The hardest cases to reach from the ports are the exact window edges. A second write must land at a gap of precisely MIN_CYC−1, MIN_CYC, MAX_CYC or MAX_CYC+1 after a pending first write. It also has to carry the same address and data, and no other write may come in between. Random traffic almost never lines all of that up. The stimulus therefore repeats the previous write half of the time and draws its idle gaps from a set that favours those four edge values. Directed sequences pin each edge once, and also pin the rule that a rejected write restarts the sequence.

// File: rtl/dwreg_pkg.sv
package dwreg_pkg;

    localparam int DW = 8;
    typedef logic [DW-1:0] byte_t;

    localparam byte_t REGA_RESET    = 8'h02;
    localparam byte_t REGB_RESET    = 8'h00;
    localparam byte_t REGA_FIX_MASK = 8'h03;
    localparam byte_t REGA_FIX_VAL  = 8'h02;
    localparam int    SRST_BIT      = 7;

    typedef enum logic {
        SEL_A = 1'b0,
        SEL_B = 1'b1
    } reg_sel_e;

    function automatic byte_t rega_fix(input byte_t v);
        return (v & ~REGA_FIX_MASK) | REGA_FIX_VAL;
    endfunction

endpackage

// File: rtl/dwreg_qual.sv
module dwreg_qual
    import dwreg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REGA_ADDR = 'h20,
    parameter logic [ADDR_W-1:0] REGB_ADDR = 'h21,
    parameter int MIN_CYC = 35,
    parameter int MAX_CYC = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  byte_t             wdata_i,
    output logic              hit_o,
    output reg_sel_e          hit_sel_o,
    output byte_t             hit_data_o
);

    localparam int CNT_W = $clog2(MAX_CYC + 2);
    localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_CYC);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_CYC);

    typedef struct packed {
        logic             pend;
        reg_sel_e         sel;
        byte_t            data;
        logic [CNT_W-1:0] cnt;
    } qual_t;

    qual_t    q_d, q_q;
    logic     mapped;
    reg_sel_e asel;
    logic     hit_d;

    assign mapped = (addr_i == REGA_ADDR) || (addr_i == REGB_ADDR);
    assign asel   = reg_sel_e'(addr_i == REGB_ADDR);

    always_comb begin
        q_d   = q_q;
        hit_d = 1'b0;
        if (wr_i && mapped) begin
            if (q_q.pend && (q_q.sel == asel) && (q_q.data == wdata_i) &&
                (q_q.cnt >= MIN_C) && (q_q.cnt <= MAX_C)) begin
                hit_d    = 1'b1;
                q_d.pend = 1'b0;
                q_d.cnt  = '0;
            end else begin
                q_d.pend = 1'b1;
                q_d.sel  = asel;
                q_d.data = wdata_i;
                q_d.cnt  = CNT_W'(1);
            end
        end else if (wr_i) begin
            q_d.pend = 1'b0;
            q_d.cnt  = '0;
        end else if (q_q.pend) begin
            if (q_q.cnt > MAX_C) begin
                q_d.pend = 1'b0;
                q_d.cnt  = '0;
            end else begin
                q_d.cnt = q_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '{pend: 1'b0, sel: SEL_A, data: '0, cnt: '0};
        else        q_q <= q_d;
    end

    assign hit_o      = hit_d;
    assign hit_sel_o  = asel;
    assign hit_data_o = wdata_i;

endmodule

// File: rtl/dwreg_store.sv
module dwreg_store
    import dwreg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     hit_i,
    input  reg_sel_e hit_sel_i,
    input  byte_t    hit_data_i,
    output byte_t    rega_o,
    output byte_t    regb_o,
    output logic     commit_a_o,
    output logic     commit_b_o,
    output logic     clr_o
);

    typedef struct packed {
        byte_t rega;
        byte_t regb;
        logic  ca;
        logic  cb;
        logic  clr;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.ca  = 1'b0;
        s_d.cb  = 1'b0;
        s_d.clr = 1'b0;
        if (hit_i) begin
            if (hit_sel_i == SEL_A) begin
                s_d.ca = 1'b1;
                if (hit_data_i[SRST_BIT]) begin
                    s_d.rega = REGA_RESET;
                    s_d.regb = REGB_RESET;
                    s_d.cb   = 1'b1;
                    s_d.clr  = 1'b1;
                end else begin
                    s_d.rega = rega_fix(hit_data_i);
                end
            end else begin
                s_d.regb = hit_data_i;
                s_d.cb   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{rega: REGA_RESET, regb: REGB_RESET, ca: 1'b0, cb: 1'b0, clr: 1'b0};
        else        s_q <= s_d;
    end

    assign rega_o     = s_q.rega;
    assign regb_o     = s_q.regb;
    assign commit_a_o = s_q.ca;
    assign commit_b_o = s_q.cb;
    assign clr_o      = s_q.clr;

endmodule

// File: rtl/dwreg_rdmux.sv
module dwreg_rdmux
    import dwreg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REGA_ADDR = 'h20,
    parameter logic [ADDR_W-1:0] REGB_ADDR = 'h21
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  byte_t             rega_i,
    input  byte_t             regb_i,
    output byte_t             rdata_o
);

    always_comb begin
        rdata_o = '0;
        if (addr_i == REGA_ADDR)      rdata_o = rega_i;
        else if (addr_i == REGB_ADDR) rdata_o = regb_i;
    end

endmodule

// File: rtl/dwreg_bank.sv
module dwreg_bank
    import dwreg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REGA_ADDR = 'h20,
    parameter logic [ADDR_W-1:0] REGB_ADDR = 'h21,
    parameter int MIN_CYC = 35,
    parameter int MAX_CYC = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [DW-1:0]     ctl_a_o,
    output logic [DW-1:0]     ctl_b_o,
    output logic              commit_a_o,
    output logic              commit_b_o,
    output logic              clr_coef_o
);

    logic     hit;
    reg_sel_e hit_sel;
    byte_t    hit_data;

    dwreg_qual #(
        .ADDR_W(ADDR_W), .REGA_ADDR(REGA_ADDR), .REGB_ADDR(REGB_ADDR),
        .MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC)
    ) i_qual (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .hit_o(hit), .hit_sel_o(hit_sel), .hit_data_o(hit_data)
    );

    dwreg_store i_store (
        .clk(clk), .rst_n(rst_n), .hit_i(hit), .hit_sel_i(hit_sel),
        .hit_data_i(hit_data), .rega_o(ctl_a_o), .regb_o(ctl_b_o),
        .commit_a_o(commit_a_o), .commit_b_o(commit_b_o), .clr_o(clr_coef_o)
    );

    dwreg_rdmux #(
        .ADDR_W(ADDR_W), .REGA_ADDR(REGA_ADDR), .REGB_ADDR(REGB_ADDR)
    ) i_rdmux (
        .addr_i(bus_addr), .rega_i(ctl_a_o), .regb_i(ctl_b_o), .rdata_o(bus_rdata)
    );

endmodule

// File: rtl/dwreg_bank_chk.sv
module dwreg_bank_chk #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REGA_ADDR = 'h20,
    parameter logic [ADDR_W-1:0] REGB_ADDR = 'h21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        ctl_a_o,
    input logic [7:0]        ctl_b_o,
    input logic              commit_a_o,
    input logic              commit_b_o,
    input logic              clr_coef_o
);

    assert_fixed_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_a_o[1:0] == 2'b10);

    assert_srst_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_a_o[7] == 1'b0);

    assert_clr_defaults_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_coef_o |-> (ctl_a_o == 8'h02 && ctl_b_o == 8'h00 && commit_a_o && commit_b_o));

    assert_rega_change_needs_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_a_o) |-> commit_a_o);

    assert_regb_change_needs_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_b_o) |-> commit_b_o);

    assert_commit_a_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        commit_a_o |-> $past(bus_wr && bus_addr == REGA_ADDR));

    assert_commit_b_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_b_o && !clr_coef_o) |-> $past(bus_wr && bus_addr == REGB_ADDR));

    assert_pulse_a_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        commit_a_o |=> !commit_a_o);

    assert_pulse_b_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        commit_b_o |=> !commit_b_o);

endmodule

bind dwreg_bank dwreg_bank_chk #(
    .ADDR_W(ADDR_W), .REGA_ADDR(REGA_ADDR), .REGB_ADDR(REGB_ADDR)
) i_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .ctl_a_o(ctl_a_o), .ctl_b_o(ctl_b_o), .commit_a_o(commit_a_o),
    .commit_b_o(commit_b_o), .clr_coef_o(clr_coef_o)
);

// File: tb/test_dwreg_bank.sv
module test_dwreg_bank;

    localparam int MINC = 5;
    localparam int MAXC = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata, ctl_a_o, ctl_b_o;
    logic       commit_a_o, commit_b_o, clr_coef_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    // bench model
    bit         m_pend = 1'b0;
    bit         m_sel = 1'b0;
    logic [7:0] m_data = 8'h00;
    int         m_t = 0;
    logic [7:0] m_a = 8'h02;
    logic [7:0] m_b = 8'h00;
    logic [7:0] last_a = 8'h20;
    logic [7:0] last_d = 8'h00;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dwreg_bank #(.MIN_CYC(MINC), .MAX_CYC(MAXC)) i_dwreg_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctl_a_o(ctl_a_o),
        .ctl_b_o(ctl_b_o), .commit_a_o(commit_a_o), .commit_b_o(commit_b_o),
        .clr_coef_o(clr_coef_o)
    );

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        if (a == 8'h20) return m_a;
        if (a == 8'h21) return m_b;
        return 8'h00;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the write edge
    task automatic wr(input string tag, input logic [7:0] a, input logic [7:0] d);
        int  wcyc;
        int  gap;
        bit  e_ca = 0, e_cb = 0, e_clr = 0;
        bit  asel;
        logic [7:0] ra;
        wcyc = cyc + 1;
        gap  = wcyc - m_t;
        asel = (a == 8'h21);
        if (a == 8'h20 || a == 8'h21) begin
            if (m_pend && m_sel == asel && m_data == d && gap >= MINC && gap <= MAXC) begin
                m_pend = 0;
                if (!asel) begin
                    e_ca = 1;
                    if (d[7]) begin
                        m_a = 8'h02; m_b = 8'h00; e_cb = 1; e_clr = 1;
                    end else begin
                        m_a = {d[7:2], 2'b10};
                    end
                end else begin
                    m_b = d; e_cb = 1;
                end
            end else begin
                m_pend = 1; m_sel = asel; m_data = d; m_t = wcyc;
            end
        end else begin
            m_pend = 0;
        end
        last_a = a; last_d = d;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        check({tag, " commit_a"}, commit_a_o, e_ca);
        check({tag, " commit_b"}, commit_b_o, e_cb);
        check({tag, " clr_coef"}, clr_coef_o, e_clr);
        check({tag, " ctl_a"}, ctl_a_o, m_a);
        check({tag, " ctl_b"}, ctl_b_o, m_b);
        case ($urandom % 3)
            0: ra = 8'h20;
            1: ra = 8'h21;
            default: ra = 8'h00 + 8'($urandom % 32);
        endcase
        bus_addr = ra;
        #1;
        check("R9 readback", bus_rdata, exp_rd(ra));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R10 pulses idle", {commit_a_o, commit_b_o, clr_coef_o}, 3'b000);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check("R1 ctl_a reset", ctl_a_o, 8'h02);
        check("R1 ctl_b reset", ctl_b_o, 8'h00);
        check("R1 pulses reset", {commit_a_o, commit_b_o, clr_coef_o}, 3'b000);
        rst_n = 1'b1;
        idle(2);
        bus_addr = 8'h20; #1; check("R9 read A reset", bus_rdata, 8'h02);
        bus_addr = 8'h21; #1; check("R9 read B reset", bus_rdata, 8'h00);

        // R2 gap exactly MIN
        wr("R2 first", 8'h20, 8'h54); idle(MINC - 1);
        wr("R2 min gap", 8'h20, 8'h54);
        check("R2 min commit", ctl_a_o, 8'h56);
        // R3 gap MIN-1, then restart
        idle(3);
        wr("R3 first", 8'h21, 8'h3C); idle(MINC - 2);
        wr("R3 early", 8'h21, 8'h3C);
        check("R3 no commit", ctl_b_o, 8'h00);
        idle(MINC - 1);
        wr("R3 restart", 8'h21, 8'h3C);
        check("R3 restart commit", ctl_b_o, 8'h3C);
        // R4 gap MAX+1 then MAX
        idle(2);
        wr("R4 first", 8'h21, 8'h11); idle(MAXC);
        wr("R4 late", 8'h21, 8'h11);
        check("R4 no commit", ctl_b_o, 8'h3C);
        idle(MAXC - 1);
        wr("R2 max gap", 8'h21, 8'h11);
        check("R2 max commit", ctl_b_o, 8'h11);
        // R5 data mismatch
        idle(2);
        wr("R5 first", 8'h20, 8'h40); idle(6);
        wr("R5 diff", 8'h20, 8'h44);
        check("R5 no commit", ctl_a_o, 8'h56);
        idle(6);
        wr("R5 restart", 8'h20, 8'h44);
        check("R5 restart commit", ctl_a_o, 8'h46);
        // R6 intervening writes
        idle(2);
        wr("R6 first", 8'h21, 8'h77); idle(3);
        wr("R6 unmapped", 8'h30, 8'h77); idle(3);
        wr("R6 after unmapped", 8'h21, 8'h77);
        check("R6 unmapped discards", ctl_b_o, 8'h11);
        idle(8);
        wr("R6 first2", 8'h20, 8'h08); idle(3);
        wr("R6 other reg", 8'h21, 8'h08); idle(3);
        wr("R6 after other", 8'h20, 8'h08);
        check("R6 other discards", ctl_a_o, 8'h46);
        // R7 fixed bits
        idle(8);
        wr("R7 first", 8'h20, 8'h7D); idle(7);
        wr("R7 second", 8'h20, 8'h7D);
        check("R7 fixed bits", ctl_a_o, 8'h7E);
        // R11 third write alone
        idle(2);
        wr("R11 first", 8'h21, 8'h5A); idle(MINC);
        wr("R11 second", 8'h21, 8'h5A);
        wr("R11 prep", 8'h21, 8'h5A);
        check("R11 first commit", ctl_b_o, 8'h5A);
        idle(2);
        wr("R11 first", 8'h21, 8'hA5); idle(MINC);
        wr("R11 commit", 8'h21, 8'hA5); idle(MINC);
        wr("R11 third alone", 8'h21, 8'hA5);
        check("R11 no extra pulse", commit_b_o, 1'b0);
        // R8 soft reset
        idle(2);
        wr("R8 first", 8'h20, 8'h80); idle(MINC);
        wr("R8 second", 8'h20, 8'h80);
        check("R8 clr pulse", clr_coef_o, 1'b1);
        check("R8 A default", ctl_a_o, 8'h02);
        check("R8 B default", ctl_b_o, 8'h00);
        idle(1);
        check("R8 clr one cycle", clr_coef_o, 1'b0);

        // random traffic
        for (int n = 0; n < 600; n++) begin
            logic [7:0] a, d;
            int g;
            if (($urandom % 10) < 5) begin
                a = last_a; d = last_d;
            end else begin
                case ($urandom % 5)
                    0, 1: a = 8'h20;
                    2, 3: a = 8'h21;
                    default: a = 8'h22 + 8'($urandom % 8);
                endcase
                d = 8'($urandom % 8) << 4 | 8'($urandom % 4);
                if (($urandom % 16) == 0) d[7] = 1'b1;
            end
            case ($urandom % 6)
                0: g = MINC - 2;
                1: g = MINC - 1;
                2: g = MAXC - 1;
                3: g = MAXC;
                default: g = $urandom % MAXC;
            endcase
            wr("R2 random", a, d);
            idle(g);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule